// File: doc/BRIEF.md
# Framed SPI Register Access Master

This block lets a host read and write the registers of an external power-management device over a four-wire SPI link. The host asks for one register access or a burst of several. It gives a command (read or write), a frame count and, for writes, one 24-bit value per frame. The block builds one 32-bit frame per access. Each frame carries the write flag, a 6-bit register address and the payload. The block shifts each frame out most significant bit first and captures the 32-bit word the device returns during the same frame.

A burst can take its register addresses in two ways. It can walk upward from a start register, or it can take each address from a per-slot list. The block checks every address of the burst against the register count before it touches the bus. A request that fails this check ends at once with an error, and the chip-select line never rises. The block holds chip select high for the length of each frame and drops it between frames. When the burst ends, the block reports how many frames it completed and the captured response word of each slot.

Top module: `spi_regacc_master`

## Requirements
- R1: Each frame is 32 bits sent MSB first. Bit 31 is 1 for a write and 0 for a read, bits 30:25 hold the register address, and bit 24 is always 0. Bits 23:0 carry the slot's write value for a write and zeros for a read.
- R2: SPI mode 0 at a quarter of the system clock. spi_sclk idles low, and each bit is two clocks low followed by two clocks high. spi_mosi changes only where spi_sclk falls. Every frame has exactly 32 rising edges.
- R3: spi_cs is active high and stays high for the whole of each frame. Between two frames of one burst it is low for exactly one system clock. It is low whenever the block is idle.
- R4: When req_list is 0, frame k of a burst addresses req_start + k. When req_list is 1, frame k addresses req_addrs[6k+5:6k]. List slots at or above req_count are not used.
- R5: A request is refused when req_count is 0, when req_count exceeds the slot count, or when any used address is at or above REG_COUNT. A refused request drives no bus activity, raises err with a one-cycle done, reports done_count 0, and returns all ones in every rd_data slot.
- R6: rd_data slot k (bits 32k+31:32k) holds the full 32-bit word sampled on spi_miso at the rising spi_sclk edges of frame k, first bit in bit 31. Slots not used by the last request read all ones.
- R7: For an accepted request, done pulses for one cycle, one clock after spi_cs falls at the end of the last frame. At that point done_count equals req_count and err is 0.
- R8: busy rises the clock after an accepted request and falls with done. A request presented while busy is high is ignored: it adds no frame and does not change the result of the burst in progress.
- R9: After reset, spi_cs, spi_sclk, spi_mosi, busy, done and err are 0 and done_count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Request strobe, sampled while not busy |
| req_write | input | 1 | 1 = write burst, 0 = read burst |
| req_list | input | 1 | 1 = addresses from req_addrs, 0 = ascending from req_start |
| req_count | input | CNT_W | Number of frames in the burst |
| req_start | input | 6 | First register of an ascending burst |
| req_addrs | input | MAX_FRAMES*6 | Per-slot register addresses for list bursts |
| req_wdata | input | MAX_FRAMES*24 | Per-slot write values |
| busy | output | 1 | Burst in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last request was refused |
| done_count | output | CNT_W | Frames completed by the last request |
| rd_data | output | MAX_FRAMES*32 | Captured response words, one per slot |
| spi_cs | output | 1 | Chip select, active high |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the device |
| spi_miso | input | 1 | Serial data from the device |

## Verification
The end of a burst and the arrival of the next request can fall in the same cycle. In the cycle after chip select drops on the last frame, busy is still high and done has not yet pulsed. The bench holds a request with a different address through exactly that cycle, and holds another through the following cycle, the one where done pulses. The first request must leave no frame on the bus. The second must start a burst whose frame the device model logs with the correct header. The test also checks that both completions report the right counts.

// File: rtl/spiacc_pkg.sv
package spiacc_pkg;

   localparam int FRAME_W = 32;
   localparam int ADDR_W  = 6;
   localparam int DATA_W  = 24;

   // frame layout, MSB first on the wire
   typedef struct packed {
      logic              wr;
      logic [ADDR_W-1:0] addr;
      logic              pad;
      logic [DATA_W-1:0] data;
   } frame_t;

   function automatic frame_t make_frame(input logic wr,
                                         input logic [ADDR_W-1:0] a,
                                         input logic [DATA_W-1:0] d);
      frame_t f;
      f.wr   = wr;
      f.addr = a;
      f.pad  = 1'b0;
      f.data = wr ? d : '0;
      return f;
   endfunction

endpackage

// File: rtl/spiacc_addr_sel.sv
module spiacc_addr_sel
   import spiacc_pkg::*;
#(
   parameter int MAX_FRAMES = 4,
   parameter int REG_COUNT  = 60,
   parameter int CNT_W      = 3
) (
   input  logic                         list_mode,
   input  logic [CNT_W-1:0]             count,
   input  logic [ADDR_W-1:0]            start_addr,
   input  logic [MAX_FRAMES*ADDR_W-1:0] list_addrs,
   output logic [MAX_FRAMES*ADDR_W-1:0] slot_addrs,
   output logic                         all_ok
);

   localparam int SUM_W = ADDR_W + CNT_W;

   logic [MAX_FRAMES-1:0] slot_bad;

   generate
      for (genvar k = 0; k < MAX_FRAMES; k++) begin : g_slot
         logic [SUM_W-1:0] wide;
         logic             used;
         assign wide = list_mode ? SUM_W'(list_addrs[k*ADDR_W +: ADDR_W])
                                 : SUM_W'(start_addr) + SUM_W'(k);
         assign used = CNT_W'(k) < count;
         assign slot_bad[k] = used && (wide >= SUM_W'(REG_COUNT));
         assign slot_addrs[k*ADDR_W +: ADDR_W] = wide[ADDR_W-1:0];
      end
   endgenerate

   assign all_ok = (slot_bad == '0) && (count != '0)
                   && (count <= CNT_W'(MAX_FRAMES));

endmodule

// File: rtl/spiacc_frame_engine.sv
module spiacc_frame_engine #(
   parameter int FRAME_W   = 32,
   parameter int SCLK_HALF = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [FRAME_W-1:0] tx_word,
   input  logic               miso,
   output logic               sclk,
   output logic               mosi,
   output logic               cs,
   output logic [FRAME_W-1:0] rx_word,
   output logic               frame_done
);

   localparam int BC_W = $clog2(FRAME_W);

   generate
      if (FRAME_W < 2) begin : g_bad_frame
         $error("FRAME_W must be at least 2");
      end
      if (SCLK_HALF < 1) begin : g_bad_half
         $error("SCLK_HALF must be at least 1");
      end
   endgenerate

   logic               active;
   logic               sclk_q;
   logic               fdone_q;
   logic               tick;
   logic [BC_W-1:0]    bcnt;
   logic [FRAME_W-1:0] sreg;
   logic [FRAME_W-1:0] rsh;

   // half-period timer: a variant without a counter when no division is asked
   generate
      if (SCLK_HALF == 1) begin : g_nodiv
         assign tick = 1'b1;
      end else begin : g_div
         localparam int HC_W = $clog2(SCLK_HALF);
         logic [HC_W-1:0] hc;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                      hc <= '0;
            else if (start || !active || tick) hc <= '0;
            else                             hc <= hc + 1'b1;
         end
         assign tick = (hc == HC_W'(SCLK_HALF - 1));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active  <= 1'b0;
         sclk_q  <= 1'b0;
         fdone_q <= 1'b0;
         bcnt    <= '0;
         sreg    <= '0;
         rsh     <= '0;
      end else begin
         fdone_q <= 1'b0;
         if (start) begin
            active <= 1'b1;
            sreg   <= tx_word;
            bcnt   <= '0;
            sclk_q <= 1'b0;
         end else if (active && tick) begin
            if (!sclk_q) begin
               sclk_q <= 1'b1;
               rsh    <= {rsh[FRAME_W-2:0], miso};
            end else begin
               sclk_q <= 1'b0;
               sreg   <= {sreg[FRAME_W-2:0], 1'b0};
               if (bcnt == BC_W'(FRAME_W - 1)) begin
                  active  <= 1'b0;
                  fdone_q <= 1'b1;
               end else begin
                  bcnt <= bcnt + 1'b1;
               end
            end
         end
      end
   end

   assign sclk       = sclk_q;
   assign mosi       = sreg[FRAME_W-1];
   assign cs         = active;
   assign rx_word    = rsh;
   assign frame_done = fdone_q;

   // R2
   mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (active && $past(active) && !$fell(sclk_q)) |-> $stable(sreg[FRAME_W-1]));

endmodule

// File: rtl/spi_regacc_master.sv
module spi_regacc_master
   import spiacc_pkg::*;
#(
   parameter int REG_COUNT  = 60,
   parameter int MAX_FRAMES = 4,
   parameter int SCLK_HALF  = 2,
   parameter int CNT_W      = $clog2(MAX_FRAMES + 1)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          req,
   input  logic                          req_write,
   input  logic                          req_list,
   input  logic [CNT_W-1:0]              req_count,
   input  logic [ADDR_W-1:0]             req_start,
   input  logic [MAX_FRAMES*ADDR_W-1:0]  req_addrs,
   input  logic [MAX_FRAMES*DATA_W-1:0]  req_wdata,
   output logic                          busy,
   output logic                          done,
   output logic                          err,
   output logic [CNT_W-1:0]              done_count,
   output logic [MAX_FRAMES*FRAME_W-1:0] rd_data,
   output logic                          spi_cs,
   output logic                          spi_sclk,
   output logic                          spi_mosi,
   input  logic                          spi_miso
);

   localparam int IDX_W = (MAX_FRAMES > 1) ? $clog2(MAX_FRAMES) : 1;

   generate
      if (REG_COUNT < 1 || REG_COUNT > (1 << ADDR_W)) begin : g_bad_regs
         $error("REG_COUNT must lie in 1..64");
      end
      if (MAX_FRAMES < 1) begin : g_bad_frames
         $error("MAX_FRAMES must be at least 1");
      end
   endgenerate

   logic [MAX_FRAMES*ADDR_W-1:0] sel_addrs;
   logic                         sel_ok;

   spiacc_addr_sel #(
      .MAX_FRAMES (MAX_FRAMES),
      .REG_COUNT  (REG_COUNT),
      .CNT_W      (CNT_W)
   ) u_sel (
      .list_mode  (req_list),
      .count      (req_count),
      .start_addr (req_start),
      .list_addrs (req_addrs),
      .slot_addrs (sel_addrs),
      .all_ok     (sel_ok)
   );

   logic                          busy_q, kick_q, done_q, err_q, wr_q;
   logic [IDX_W-1:0]              fidx_q;
   logic [CNT_W-1:0]              cnt_q, dcnt_q;
   logic [MAX_FRAMES*ADDR_W-1:0]  addr_q;
   logic [MAX_FRAMES*DATA_W-1:0]  data_q;
   logic [MAX_FRAMES*FRAME_W-1:0] rd_q;

   logic [CNT_W-1:0]   nxt;
   logic               more;
   logic [IDX_W-1:0]   tx_idx;
   logic [ADDR_W-1:0]  tx_addr;
   logic [DATA_W-1:0]  tx_data;
   frame_t             tx_frame;
   logic               eng_start, eng_done, eng_cs;
   logic [FRAME_W-1:0] eng_rx;

   assign nxt      = CNT_W'(fidx_q) + 1'b1;
   assign more     = nxt < cnt_q;
   assign tx_idx   = kick_q ? '0 : IDX_W'(nxt);
   assign tx_addr  = addr_q[int'(tx_idx)*ADDR_W +: ADDR_W];
   assign tx_data  = data_q[int'(tx_idx)*DATA_W +: DATA_W];
   assign tx_frame = make_frame(wr_q, tx_addr, tx_data);
   assign eng_start = kick_q | (eng_done & more);

   spiacc_frame_engine #(
      .FRAME_W   (FRAME_W),
      .SCLK_HALF (SCLK_HALF)
   ) u_eng (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (eng_start),
      .tx_word    (tx_frame),
      .miso       (spi_miso),
      .sclk       (spi_sclk),
      .mosi       (spi_mosi),
      .cs         (eng_cs),
      .rx_word    (eng_rx),
      .frame_done (eng_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         kick_q <= 1'b0;
         done_q <= 1'b0;
         err_q  <= 1'b0;
         wr_q   <= 1'b0;
         fidx_q <= '0;
         cnt_q  <= '0;
         dcnt_q <= '0;
         addr_q <= '0;
         data_q <= '0;
         rd_q   <= '1;
      end else begin
         done_q <= 1'b0;
         kick_q <= 1'b0;
         if (req && !busy_q) begin
            rd_q   <= '1;
            err_q  <= !sel_ok;
            dcnt_q <= '0;
            if (sel_ok) begin
               busy_q <= 1'b1;
               kick_q <= 1'b1;
               fidx_q <= '0;
               cnt_q  <= req_count;
               wr_q   <= req_write;
               addr_q <= sel_addrs;
               data_q <= req_wdata;
            end else begin
               done_q <= 1'b1;
            end
         end else if (eng_done) begin
            rd_q[int'(fidx_q)*FRAME_W +: FRAME_W] <= eng_rx;
            if (more) begin
               fidx_q <= IDX_W'(nxt);
            end else begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
               dcnt_q <= cnt_q;
            end
         end
      end
   end

   assign busy       = busy_q;
   assign done       = done_q;
   assign err        = err_q;
   assign done_count = dcnt_q;
   assign rd_data    = rd_q;
   assign spi_cs     = eng_cs;

   // R7
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> (!busy_q && !eng_cs));

   // R8
   idle_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_q |-> !eng_cs);

   // R5
   range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eng_start |-> (tx_addr < ADDR_W'(REG_COUNT)));

   // R5
   refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_q && err_q) |-> (dcnt_q == '0));

   // R3
   gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_done && busy_q && more) |=> eng_cs);

endmodule

// File: tb/sim_spi_regacc_master.sv
module sim_spi_regacc_master;

   localparam int MAXF  = 4;
   localparam int CNT_W = 3;
   localparam int REGS  = 60;

   typedef struct packed {
      bit        wr;
      bit        lst;
      bit [2:0]  cnt;
      bit [5:0]  start;
      bit [23:0] addrs;
      bit [95:0] data;
      bit        eerr;
   } vec_t;

   localparam int NV = 10;
   localparam vec_t VEC [NV] = '{
      '{wr:1'b1, lst:1'b0, cnt:3'd1, start:6'd5,  addrs:24'h0, data:{72'h0, 24'h123456}, eerr:1'b0},
      '{wr:1'b0, lst:1'b0, cnt:3'd1, start:6'd59, addrs:24'h0, data:96'h0, eerr:1'b0},
      '{wr:1'b1, lst:1'b0, cnt:3'd4, start:6'd10, addrs:24'h0,
        data:{24'hFEDCBA, 24'h00F00F, 24'h800001, 24'h7FFFFE}, eerr:1'b0},
      '{wr:1'b0, lst:1'b1, cnt:3'd4, start:6'd0,
        addrs:{6'd33, 6'd0, 6'd59, 6'd3}, data:96'h0, eerr:1'b0},
      '{wr:1'b0, lst:1'b0, cnt:3'd1, start:6'd60, addrs:24'h0, data:96'h0, eerr:1'b1},
      '{wr:1'b1, lst:1'b0, cnt:3'd4, start:6'd57, addrs:24'h0, data:96'h0, eerr:1'b1},
      '{wr:1'b1, lst:1'b1, cnt:3'd3, start:6'd0,
        addrs:{6'd63, 6'd21, 6'd42, 6'd1}, data:{24'h0, 24'hABCDEF, 24'h555555, 24'hAAAAAA}, eerr:1'b0},
      '{wr:1'b0, lst:1'b0, cnt:3'd0, start:6'd2,  addrs:24'h0, data:96'h0, eerr:1'b1},
      '{wr:1'b1, lst:1'b1, cnt:3'd2, start:6'd0,
        addrs:{12'h0, 6'd62, 6'd4}, data:96'h0, eerr:1'b1},
      '{wr:1'b0, lst:1'b0, cnt:3'd4, start:6'd56, addrs:24'h0, data:96'h0, eerr:1'b0}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req = 1'b0, req_write = 1'b0, req_list = 1'b0;
   logic [CNT_W-1:0] req_count = '0;
   logic [5:0]       req_start = '0;
   logic [23:0]      req_addrs = '0;
   logic [95:0]      req_wdata = '0;
   logic busy, done, err, spi_cs, spi_sclk, spi_mosi;
   logic spi_miso = 1'b0;
   logic [CNT_W-1:0] done_count;
   logic [127:0]     rd_data;

   always #4 clk = ~clk;

   spi_regacc_master #(.REG_COUNT(REGS), .MAX_FRAMES(MAXF)) u0 (
      .clk(clk), .rst_n(rst_n), .req(req), .req_write(req_write),
      .req_list(req_list), .req_count(req_count), .req_start(req_start),
      .req_addrs(req_addrs), .req_wdata(req_wdata), .busy(busy),
      .done(done), .err(err), .done_count(done_count), .rd_data(rd_data),
      .spi_cs(spi_cs), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
      .spi_miso(spi_miso));

   int total = 0;
   int fails = 0;

   task automatic chk(input bit ok, input string rq, input logic [63:0] act,
                      input logic [63:0] exp);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
      end
   endtask

   function automatic logic [31:0] resp_of(input int n);
      return 32'h9D2C5A17 + 32'(n) * 32'h01234567;
   endfunction

   // device model: mode 0 slave that logs frames and returns resp_of(n)
   int          nfr = 0;
   int          sbit = 0;
   int          npos = 0;
   logic [31:0] cur = '0;
   logic [31:0] rxs = '0;
   logic [31:0] flog [64];
   int          fpos [64];

   always @(posedge spi_cs) begin
      cur = resp_of(nfr);
      sbit = 31;
      spi_miso = cur[31];
      rxs = '0;
      npos = 0;
   end
   always @(negedge spi_sclk) begin
      if (spi_cs && sbit > 0) begin
         sbit = sbit - 1;
         spi_miso = cur[sbit];
      end
   end
   always @(posedge spi_sclk) begin
      if (spi_cs) begin
         rxs = {rxs[30:0], spi_mosi};
         npos++;
      end
   end
   always @(negedge spi_cs) begin
      if (nfr < 64) begin
         flog[nfr] = rxs;
         fpos[nfr] = npos;
      end
      nfr++;
   end

   // bus timing monitors
   int  gap_bad = 0, clk_bad = 0, idle_bad = 0, done_bad = 0;
   int  gaplen = 0, run = 0;
   bit  lvl = 1'b0, seen = 1'b0, cs_d1 = 1'b0, cs_d2 = 1'b0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (spi_cs) begin
            seen = 1'b1;
            if (gaplen > 0 && gaplen != 1) gap_bad++;
            gaplen = 0;
            if (spi_sclk == lvl) run++;
            else begin
               if (run != 2) clk_bad++;
               lvl = spi_sclk;
               run = 1;
            end
         end else begin
            lvl = 1'b0;
            run = 0;
            if (busy && seen) gaplen++;
            if (!busy) begin
               seen = 1'b0;
               gaplen = 0;
               if (spi_sclk) idle_bad++;
            end
         end
         if (done && !(cs_d1 == 1'b0 && cs_d2 == 1'b1) && !err) done_bad++;
         cs_d2 = cs_d1;
         cs_d1 = spi_cs;
      end
   end

   task automatic issue(input vec_t v);
      @(negedge clk);
      req = 1'b1; req_write = v.wr; req_list = v.lst; req_count = v.cnt;
      req_start = v.start; req_addrs = v.addrs; req_wdata = v.data;
      @(negedge clk);
      req = 1'b0;
   endtask

   task automatic wait_done(input string rq);
      int t = 0;
      while (!done && t < 3000) begin
         @(negedge clk);
         t++;
      end
      chk(done == 1'b1, {rq, " done seen"}, 64'(done), 64'd1);
   endtask

   function automatic logic [31:0] exp_frame(input vec_t v, input int k);
      logic [5:0] a;
      a = v.lst ? v.addrs[k*6 +: 6] : 6'(v.start + 6'(k));
      return {v.wr, a, 1'b0, v.wr ? v.data[k*24 +: 24] : 24'h0};
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      total++;
      fails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
      $finish;
   end

   initial begin
      int n0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R9 reset state
      chk({spi_cs, spi_sclk, spi_mosi, busy, done, err} == 6'b0, "R9 outputs",
          64'({spi_cs, spi_sclk, spi_mosi, busy, done, err}), 64'd0);
      chk(done_count == '0, "R9 done_count", 64'(done_count), 64'd0);

      // table walk: R1 R2 R3 R4 R5 R6 R7
      for (int i = 0; i < NV; i++) begin
         vec_t v = VEC[i];
         n0 = nfr;
         gap_bad = 0; clk_bad = 0; done_bad = 0;
         issue(v);
         wait_done("R7");
         chk(err == v.eerr, "R5 err flag", 64'(err), 64'(v.eerr));
         chk(done_count == (v.eerr ? 3'd0 : v.cnt), "R7 done_count",
             64'(done_count), 64'(v.eerr ? 3'd0 : v.cnt));
         for (int k = 0; k < MAXF; k++) begin
            logic [31:0] e;
            e = (!v.eerr && k < int'(v.cnt)) ? resp_of(n0 + k) : 32'hFFFFFFFF;
            chk(rd_data[k*32 +: 32] == e, "R6 rd slot", 64'(rd_data[k*32 +: 32]), 64'(e));
         end
         if (v.eerr) begin
            chk(nfr == n0, "R5 no bus activity", 64'(nfr - n0), 64'd0);
         end else begin
            chk(nfr == n0 + int'(v.cnt), "R4 frame count", 64'(nfr - n0), 64'(v.cnt));
            for (int k = 0; k < int'(v.cnt); k++) begin
               chk(flog[n0 + k] == exp_frame(v, k), "R1 R4 frame bits",
                   64'(flog[n0 + k]), 64'(exp_frame(v, k)));
               chk(fpos[n0 + k] == 32, "R2 edges per frame", 64'(fpos[n0 + k]), 64'd32);
            end
            chk(clk_bad == 0, "R2 sclk phase lengths", 64'(clk_bad), 64'd0);
            chk(gap_bad == 0, "R3 one-clock cs gap", 64'(gap_bad), 64'd0);
            chk(done_bad == 0, "R7 done one clock after cs fall", 64'(done_bad), 64'd0);
         end
         @(negedge clk);
         chk(done == 1'b0 && busy == 1'b0, "R7 single-cycle done", 64'({done, busy}), 64'd0);
      end
      chk(idle_bad == 0, "R3 idle bus quiet", 64'(idle_bad), 64'd0);

      // R8: request during a burst is ignored
      begin
         vec_t a, b;
         a = '{wr:1'b1, lst:1'b0, cnt:3'd2, start:6'd20, addrs:24'h0,
               data:{48'h0, 24'h0BEEF0, 24'h13579B}, eerr:1'b0};
         b = '{wr:1'b0, lst:1'b1, cnt:3'd1, start:6'd0, addrs:{18'h0, 6'd9},
               data:96'h0, eerr:1'b0};
         n0 = nfr;
         issue(a);
         chk(busy == 1'b1, "R8 busy after accept", 64'(busy), 64'd1);
         repeat (40) @(negedge clk);
         issue(b);
         wait_done("R8");
         chk(nfr == n0 + 2, "R8 ignored request adds no frame", 64'(nfr - n0), 64'd2);
         chk(flog[n0 + 1] == exp_frame(a, 1), "R8 burst intact",
             64'(flog[n0 + 1]), 64'(exp_frame(a, 1)));
         chk(done_count == 3'd2, "R8 done_count", 64'(done_count), 64'd2);
      end

      // same-cycle case: request in the cs-fall cycle is ignored, the next is taken
      begin
         vec_t a, b, c;
         a = '{wr:1'b0, lst:1'b0, cnt:3'd1, start:6'd30, addrs:24'h0, data:96'h0, eerr:1'b0};
         b = '{wr:1'b1, lst:1'b0, cnt:3'd1, start:6'd7, addrs:24'h0,
               data:{72'h0, 24'h777777}, eerr:1'b0};
         c = '{wr:1'b1, lst:1'b0, cnt:3'd1, start:6'd44, addrs:24'h0,
               data:{72'h0, 24'h0C0DE0}, eerr:1'b0};
         n0 = nfr;
         issue(a);
         @(negedge spi_cs);
         @(negedge clk);
         chk(busy == 1'b1 && done == 1'b0, "R8 busy in cs-fall cycle", 64'({busy, done}), 64'h2);
         req = 1'b1; req_write = b.wr; req_list = b.lst; req_count = b.cnt;
         req_start = b.start; req_wdata = b.data;
         @(negedge clk);
         chk(done == 1'b1 && done_count == 3'd1, "R7 done after cs fall",
             64'({done, done_count}), 64'h9);
         req_write = c.wr; req_start = c.start; req_wdata = c.data;
         @(negedge clk);
         req = 1'b0;
         chk(busy == 1'b1, "R8 accepted on done cycle", 64'(busy), 64'd1);
         wait_done("R8");
         chk(nfr == n0 + 2, "R8 only one extra frame", 64'(nfr - n0), 64'd2);
         chk(flog[n0 + 1] == exp_frame(c, 0), "R1 follow-on frame",
             64'(flog[n0 + 1]), 64'(exp_frame(c, 0)));
         chk(rd_data[31:0] == resp_of(n0 + 1), "R6 follow-on capture",
             64'(rd_data[31:0]), 64'(resp_of(n0 + 1)));
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
      $finish;
   end

endmodule